// File: doc/BRIEF.md
# Segment-Aware Call/Return Stack Sequencer

This block keeps the system stack of a processor whose code space is split into segments. It handles four events: subroutine call, subroutine return, interrupt entry and interrupt exit. On each event it moves one word per clock between the processor's pointer registers and a stack memory inside the block. The registers involved are a 16-bit instruction pointer, an 8-bit code segment pointer and a 16-bit status word. While a multi-word transfer is running, a busy flag is raised. When a pop sequence ends, the restored pointers appear on the outputs.

A configuration register holds two settings. A flat-mode bit decides whether the segment pointer travels with the instruction pointer. A 3-bit size code picks how many words of the memory form the stack. The stack grows downward from the top of the memory and wraps around within the selected size. The virtual depth of calls can therefore exceed the physical area, and the oldest entries are overwritten.

Top module: `cstk_sequencer`

## Requirements
- R1: After a synchronous reset, sp_out is 0, busy and done are 0, ip_out, seg_out and psw_out are 0, flat mode is off (segmented) and the size code is 0 (32 words).
- R2: In segmented mode a call pushes the segment pointer and then the instruction pointer (busy for 2 cycles). A return pops the instruction pointer and then the segment pointer, restoring both.
- R3: In flat mode a call pushes only the instruction pointer (busy for 1 cycle). A return restores only ip_out, and seg_out keeps its previous value.
- R4: Interrupt entry pushes the status word, then the segment pointer if segmented, then the instruction pointer (3 or 2 cycles). Interrupt exit pops in reverse order and restores psw_out as well.
- R5: A one-cycle pulse on cfg_wr loads cfg_flat and cfg_size. The mode that applies to a sequence is the one registered at the clock edge that accepts the request, so a configuration write in that same cycle affects only later requests.
- R6: Size codes 0 to 5 select 32, 64, 128, 256, 512 and 1024 words, and codes 6 and 7 select 1024. After N single-word pushes from reset, sp_out equals (1024 − (N mod S)) mod 1024 for stack size S.
- R7: A push first decrements the pointer and then writes at the new sp_out. A pop reads at sp_out and then increments the pointer, so words come back last-in first-out.
- R8: busy is high from the edge that accepts a request until the edge that moves the final word. A request present at any edge while busy is high, including the final-word edge, is ignored.
- R9: When several requests arrive in the same cycle, interrupt entry wins over interrupt exit, which wins over call, which wins over return.
- R10: done is high for exactly one cycle, the cycle right after the final word moves. In that cycle busy is low and the restored values are already on the outputs.
- R11: Mixed, nested calls and interrupts unwind in last-in first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load configuration this cycle |
| cfg_flat | input | 1 | Flat mode: segment pointer not stacked |
| cfg_size | input | 3 | Stack size code |
| req_call | input | 1 | Subroutine call request |
| req_ret | input | 1 | Subroutine return request |
| req_irq | input | 1 | Interrupt entry request |
| req_iret | input | 1 | Interrupt exit request |
| ip_in | input | IP_W | Instruction pointer to save |
| seg_in | input | SEG_W | Segment pointer to save |
| psw_in | input | PSW_W | Status word to save |
| busy | output | 1 | Transfer sequence in progress |
| done | output | 1 | One-cycle pulse after a sequence ends |
| sp_out | output | AW | Current stack pointer |
| ip_out | output | IP_W | Restored instruction pointer |
| seg_out | output | SEG_W | Restored segment pointer |
| psw_out | output | PSW_W | Restored status word |

## Verification
The bench builds the block with its defaults: a 10-bit address (1024-word memory) and 16-bit data words. With these values every size code can be reached, including the two codes that clamp to the largest size. Wrap-around is driven past the end for each of the eight codes. The 32-word setting is also unwound to show which entries survived the overwrite.

// File: rtl/cstk_pkg.sv
package cstk_pkg;

    typedef enum logic [1:0] {
        WK_IP  = 2'd0,
        WK_SEG = 2'd1,
        WK_PSW = 2'd2
    } wkind_e;

    typedef enum logic [2:0] {
        EV_NONE = 3'd0,
        EV_CALL = 3'd1,
        EV_RET  = 3'd2,
        EV_IRQ  = 3'd3,
        EV_IRET = 3'd4
    } cevt_e;

    // Word transfer plan: direction, word count, and kind of each slot in order.
    typedef struct packed {
        logic       pop;
        logic [1:0] cnt;
        wkind_e     k0;
        wkind_e     k1;
        wkind_e     k2;
    } plan_t;

    localparam int MIN_LOG   = 5;
    localparam int NUM_CODES = 6;

    // Fixed priority: interrupt entry, interrupt exit, call, return.
    function automatic cevt_e pick_event(logic call, logic ret, logic irq, logic iret);
        if (irq)       return EV_IRQ;
        else if (iret) return EV_IRET;
        else if (call) return EV_CALL;
        else if (ret)  return EV_RET;
        else           return EV_NONE;
    endfunction

    function automatic plan_t make_plan(cevt_e ev, logic flat);
        plan_t p;
        p = '{pop: 1'b0, cnt: 2'd0, k0: WK_IP, k1: WK_IP, k2: WK_IP};
        case (ev)
            EV_CALL: begin
                if (flat) begin
                    p.cnt = 2'd1;
                end else begin
                    p.cnt = 2'd2;
                    p.k0  = WK_SEG;
                end
            end
            EV_RET: begin
                p.pop = 1'b1;
                if (flat) begin
                    p.cnt = 2'd1;
                end else begin
                    p.cnt = 2'd2;
                    p.k1  = WK_SEG;
                end
            end
            EV_IRQ: begin
                p.k0 = WK_PSW;
                if (flat) begin
                    p.cnt = 2'd2;
                end else begin
                    p.cnt = 2'd3;
                    p.k1  = WK_SEG;
                end
            end
            EV_IRET: begin
                p.pop = 1'b1;
                if (flat) begin
                    p.cnt = 2'd2;
                    p.k1  = WK_PSW;
                end else begin
                    p.cnt = 2'd3;
                    p.k1  = WK_SEG;
                    p.k2  = WK_PSW;
                end
            end
            default: ;
        endcase
        return p;
    endfunction

    function automatic wkind_e kind_at(plan_t p, logic [1:0] i);
        case (i)
            2'd0:    return p.k0;
            2'd1:    return p.k1;
            default: return p.k2;
        endcase
    endfunction

    // log2 of the stack size for a code; out-of-range codes and sizes clamp to the maximum.
    function automatic int size_log(logic [2:0] code, int max_log);
        int l;
        if (int'(code) < NUM_CODES) l = MIN_LOG + int'(code);
        else                        l = max_log;
        if (l > max_log) l = max_log;
        return l;
    endfunction

endpackage

// File: rtl/cstk_cfg.sv
module cstk_cfg
    import cstk_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic          flat_in,
    input  logic [2:0]    code_in,
    output logic          flat,
    output logic [AW-1:0] mask
);

    logic [2:0] code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flat   <= 1'b0;
            code_q <= 3'd0;
        end else if (wr) begin
            flat   <= flat_in;
            code_q <= code_in;
        end
    end

    always_comb begin
        mask = AW'((32'd1 << size_log(code_q, AW)) - 32'd1);
    end

    // R5: configuration changes only on a write
    a_r5_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(flat));

endmodule

// File: rtl/cstk_ptr.sv
module cstk_ptr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] mask,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] sp
);

    localparam logic [AW-1:0] TOP = '1;
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] off_q;
    logic [AW-1:0] eff;
    logic [AW-1:0] dec;

    always_comb begin
        eff  = off_q & mask;
        dec  = (eff - ONE) & mask;
        addr = pop ? (TOP - dec) : (TOP - eff);
        sp   = '0 - eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q <= '0;
        end else if (push) begin
            off_q <= (eff + ONE) & mask;
        end else if (pop) begin
            off_q <= dec;
        end
    end

    // R6: every access lands inside the selected region below the top
    a_r6_in_region: assert property (@(posedge clk) disable iff (rst)
        (push || pop) |-> ((TOP - addr) <= mask));

    // R7: each push moves the pointer
    a_r7_push_moves: assert property (@(posedge clk) disable iff (rst)
        push |=> (off_q != $past(off_q)));

    // R7: each pop moves the pointer
    a_r7_pop_moves: assert property (@(posedge clk) disable iff (rst)
        pop |=> (off_q != $past(off_q)));

endmodule

// File: rtl/cstk_ram.sv
module cstk_ram #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/cstk_ctrl.sv
module cstk_ctrl
    import cstk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   call,
    input  logic   ret,
    input  logic   irq,
    input  logic   iret,
    input  logic   flat,
    output logic   busy,
    output logic   done,
    output logic   accept,
    output logic   push,
    output logic   pop,
    output wkind_e kind
);

    typedef enum logic {ST_IDLE, ST_RUN} st_e;

    st_e        st_q;
    plan_t      plan_q;
    logic [1:0] idx_q;
    logic       last;
    cevt_e      ev;

    always_comb begin
        ev     = pick_event(call, ret, irq, iret);
        accept = (st_q == ST_IDLE) && (ev != EV_NONE);
        last   = (idx_q == (plan_q.cnt - 2'd1));
        busy   = (st_q == ST_RUN);
        push   = busy && !plan_q.pop;
        pop    = busy && plan_q.pop;
        kind   = kind_at(plan_q, idx_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            plan_q <= '0;
            idx_q  <= 2'd0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        plan_q <= make_plan(ev, flat);
                        idx_q  <= 2'd0;
                        st_q   <= ST_RUN;
                    end
                end
                default: begin
                    if (last) begin
                        st_q <= ST_IDLE;
                        done <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 2'd1;
                    end
                end
            endcase
        end
    end

    // R8: an accepted request raises busy on the next cycle
    a_r8_accept_busy: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

    // R8: a running sequence continues and its plan is not replaced
    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> (busy && $stable(plan_q)));

    // R10: done lasts a single cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/cstk_sequencer.sv
module cstk_sequencer
    import cstk_pkg::*;
#(
    parameter int IP_W  = 16,
    parameter int SEG_W = 8,
    parameter int PSW_W = 16,
    parameter int DW    = 16,
    parameter int AW    = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             cfg_flat,
    input  logic [2:0]       cfg_size,
    input  logic             req_call,
    input  logic             req_ret,
    input  logic             req_irq,
    input  logic             req_iret,
    input  logic [IP_W-1:0]  ip_in,
    input  logic [SEG_W-1:0] seg_in,
    input  logic [PSW_W-1:0] psw_in,
    output logic             busy,
    output logic             done,
    output logic [AW-1:0]    sp_out,
    output logic [IP_W-1:0]  ip_out,
    output logic [SEG_W-1:0] seg_out,
    output logic [PSW_W-1:0] psw_out
);

    logic             flat;
    logic [AW-1:0]    mask;
    logic             accept;
    logic             push;
    logic             pop;
    wkind_e           kind;
    logic [AW-1:0]    addr;
    logic [DW-1:0]    wdata;
    logic [DW-1:0]    rdata;
    logic [IP_W-1:0]  cap_ip;
    logic [SEG_W-1:0] cap_seg;
    logic [PSW_W-1:0] cap_psw;

    cstk_cfg #(.AW(AW)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr      (cfg_wr),
        .flat_in (cfg_flat),
        .code_in (cfg_size),
        .flat    (flat),
        .mask    (mask)
    );

    cstk_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .call   (req_call),
        .ret    (req_ret),
        .irq    (req_irq),
        .iret   (req_iret),
        .flat   (flat),
        .busy   (busy),
        .done   (done),
        .accept (accept),
        .push   (push),
        .pop    (pop),
        .kind   (kind)
    );

    cstk_ptr #(.AW(AW)) u_ptr (
        .clk  (clk),
        .rst  (rst),
        .mask (mask),
        .push (push),
        .pop  (pop),
        .addr (addr),
        .sp   (sp_out)
    );

    cstk_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (push),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_ip  <= '0;
            cap_seg <= '0;
            cap_psw <= '0;
        end else if (accept) begin
            cap_ip  <= ip_in;
            cap_seg <= seg_in;
            cap_psw <= psw_in;
        end
    end

    always_comb begin
        case (kind)
            WK_SEG:  wdata = DW'(cap_seg);
            WK_PSW:  wdata = DW'(cap_psw);
            default: wdata = DW'(cap_ip);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ip_out  <= '0;
            seg_out <= '0;
            psw_out <= '0;
        end else if (pop) begin
            case (kind)
                WK_SEG:  seg_out <= rdata[SEG_W-1:0];
                WK_PSW:  psw_out <= rdata[PSW_W-1:0];
                default: ip_out  <= rdata[IP_W-1:0];
            endcase
        end
    end

    // R3: the segment output moves only when a segment word is popped
    a_r3_seg_keep: assert property (@(posedge clk) disable iff (rst)
        !(pop && kind == WK_SEG) |=> $stable(seg_out));

    // R4: the status output moves only when a status word is popped
    a_r4_psw_keep: assert property (@(posedge clk) disable iff (rst)
        !(pop && kind == WK_PSW) |=> $stable(psw_out));

endmodule

// File: tb/cstk_sequencer_test.sv
module cstk_sequencer_test;

    localparam int IP_W = 16, SEG_W = 8, PSW_W = 16, DW = 16, AW = 10;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, cfg_wr, cfg_flat;
    logic [2:0] cfg_size;
    logic req_call, req_ret, req_irq, req_iret;
    logic [IP_W-1:0] ip_in;
    logic [SEG_W-1:0] seg_in;
    logic [PSW_W-1:0] psw_in;
    logic busy, done;
    logic [AW-1:0] sp_out;
    logic [IP_W-1:0] ip_out;
    logic [SEG_W-1:0] seg_out;
    logic [PSW_W-1:0] psw_out;

    cstk_sequencer #(.IP_W(IP_W), .SEG_W(SEG_W), .PSW_W(PSW_W), .DW(DW), .AW(AW)) uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_flat(cfg_flat), .cfg_size(cfg_size),
        .req_call(req_call), .req_ret(req_ret), .req_irq(req_irq), .req_iret(req_iret),
        .ip_in(ip_in), .seg_in(seg_in), .psw_in(psw_in), .busy(busy), .done(done),
        .sp_out(sp_out), .ip_out(ip_out), .seg_out(seg_out), .psw_out(psw_out)
    );

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // ---------------- behavioural reference model ----------------
    // step codes: 0 push ip, 1 push seg, 2 push psw, 3 pop ip, 4 pop seg, 5 pop psw
    logic [15:0] m_mem [DEPTH];
    int q[$];
    int m_off = 0, m_size = 32;
    bit m_flat = 0, e_done = 0;
    int c_ip = 0, c_seg = 0, c_psw = 0;
    int e_ip = 0, e_seg = 0, e_psw = 0;

    function automatic int size_of(int code);
        return (code < 6) ? (32 << code) : 1024;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_off = 0; m_size = 32; m_flat = 0; e_done = 0;
            e_ip = 0; e_seg = 0; e_psw = 0;
        end else begin
            e_done = 0;
            if (q.size() > 0) begin
                int st;
                st = q.pop_front();
                if (st < 3) begin
                    m_mem[DEPTH - 1 - m_off] = (st == 0) ? 16'(c_ip) : (st == 1) ? 16'(c_seg) : 16'(c_psw);
                    m_off = (m_off + 1) % m_size;
                end else begin
                    m_off = (m_off + m_size - 1) % m_size;
                    if (st == 3) e_ip = int'(m_mem[DEPTH - 1 - m_off]);
                    else if (st == 4) e_seg = int'(m_mem[DEPTH - 1 - m_off]) & 8'hFF;
                    else e_psw = int'(m_mem[DEPTH - 1 - m_off]);
                end
                if (q.size() == 0) e_done = 1;
            end else if (req_irq || req_iret || req_call || req_ret) begin
                c_ip = int'(ip_in); c_seg = int'(seg_in); c_psw = int'(psw_in);
                if (req_irq) begin
                    q.push_back(2); if (!m_flat) q.push_back(1); q.push_back(0);
                end else if (req_iret) begin
                    q.push_back(3); if (!m_flat) q.push_back(4); q.push_back(5);
                end else if (req_call) begin
                    if (!m_flat) q.push_back(1); q.push_back(0);
                end else begin
                    q.push_back(3); if (!m_flat) q.push_back(4);
                end
            end
            if (cfg_wr) begin
                m_flat = cfg_flat;
                m_size = size_of(int'(cfg_size));
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        int e_sp;
        e_sp = (DEPTH - m_off) % DEPTH;
        checks++;
        if (busy !== (q.size() > 0) || done !== e_done || int'(sp_out) !== e_sp ||
            int'(ip_out) !== e_ip || int'(seg_out) !== e_seg || int'(psw_out) !== e_psw) begin
            errors++;
            $display("FAIL %s model: busy=%0b/%0b done=%0b/%0b sp=%0d/%0d ip=%h/%h seg=%h/%h psw=%h/%h",
                     cur_req, busy, q.size() > 0, done, e_done, sp_out, e_sp,
                     ip_out, e_ip, seg_out, e_seg, psw_out, e_psw);
        end
    end

    task automatic expect_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_cfg(input bit flat, input int code);
        @(negedge clk);
        cfg_wr = 1; cfg_flat = flat; cfg_size = 3'(code);
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    // m: bit0 call, bit1 ret, bit2 irq, bit3 iret
    task automatic fire(input bit [3:0] m, input int ip, input int seg, input int psw,
                        output int cyc, output bit dn);
        @(negedge clk);
        {req_iret, req_irq, req_ret, req_call} = m;
        ip_in = 16'(ip); seg_in = 8'(seg); psw_in = 16'(psw);
        @(negedge clk);
        {req_iret, req_irq, req_ret, req_call} = 4'b0;
        cyc = 0;
        while (busy) begin cyc++; @(negedge clk); end
        dn = done;
        @(negedge clk);
        dn = dn && !done;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc; bit dn;
        rst = 1; cfg_wr = 0; cfg_flat = 0; cfg_size = 0;
        req_call = 0; req_ret = 0; req_irq = 0; req_iret = 0;
        ip_in = 0; seg_in = 0; psw_in = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        cur_req = "R1";
        expect_eq("R1", "sp", int'(sp_out), 0);
        expect_eq("R1", "busy", int'(busy), 0);
        expect_eq("R1", "ip", int'(ip_out), 0);
        expect_eq("R1", "seg", int'(seg_out), 0);

        // R2 segmented call/return (R1: segmented after reset)
        cur_req = "R2";
        fire(4'b0001, 'h1234, 'h5A, 0, cyc, dn);
        expect_eq("R2", "call cycles", cyc, 2);
        expect_eq("R7", "sp after 2 pushes", int'(sp_out), DEPTH - 2);
        fire(4'b0010, 0, 0, 0, cyc, dn);
        expect_eq("R2", "ret cycles", cyc, 2);
        expect_eq("R2", "ip", int'(ip_out), 'h1234);
        expect_eq("R2", "seg", int'(seg_out), 'h5A);
        expect_eq("R10", "done pulse", int'(dn), 1);

        // R3 flat mode
        cur_req = "R3";
        do_cfg(1, 0);
        fire(4'b0001, 'hABCD, 'h77, 0, cyc, dn);
        expect_eq("R3", "call cycles", cyc, 1);
        expect_eq("R7", "sp after 1 push", int'(sp_out), DEPTH - 1);
        fire(4'b0010, 0, 'h11, 0, cyc, dn);
        expect_eq("R3", "ret cycles", cyc, 1);
        expect_eq("R3", "ip", int'(ip_out), 'hABCD);
        expect_eq("R3", "seg unchanged", int'(seg_out), 'h5A);

        // R4 interrupt entry/exit, both modes
        cur_req = "R4";
        do_cfg(0, 0);
        fire(4'b0100, 'h4321, 'h3C, 'hBEEF, cyc, dn);
        expect_eq("R4", "irq cycles seg", cyc, 3);
        fire(4'b1000, 0, 0, 0, cyc, dn);
        expect_eq("R4", "iret cycles seg", cyc, 3);
        expect_eq("R4", "ip", int'(ip_out), 'h4321);
        expect_eq("R4", "seg", int'(seg_out), 'h3C);
        expect_eq("R4", "psw", int'(psw_out), 'hBEEF);
        do_cfg(1, 0);
        fire(4'b0100, 'h2222, 'h99, 'h1111, cyc, dn);
        expect_eq("R4", "irq cycles flat", cyc, 2);
        fire(4'b1000, 0, 0, 0, cyc, dn);
        expect_eq("R4", "iret cycles flat", cyc, 2);
        expect_eq("R4", "psw flat", int'(psw_out), 'h1111);
        expect_eq("R4", "seg kept flat", int'(seg_out), 'h3C);

        // R9 priority
        cur_req = "R9";
        do_cfg(0, 0);
        fire(4'b0101, 'h0505, 'h06, 'h0707, cyc, dn);
        expect_eq("R9", "irq over call", cyc, 3);
        fire(4'b1010, 0, 0, 0, cyc, dn);
        expect_eq("R9", "iret over ret", cyc, 3);
        expect_eq("R9", "psw restored", int'(psw_out), 'h0707);
        fire(4'b0011, 'h0909, 'h0A, 0, cyc, dn);
        expect_eq("R9", "call over ret", int'(sp_out), DEPTH - 2);
        fire(4'b0010, 0, 0, 0, cyc, dn);

        // R8 requests while busy are ignored, including at the final-word edge
        cur_req = "R8";
        @(negedge clk);
        req_call = 1; ip_in = 16'h0C0C; seg_in = 8'h0D;
        @(negedge clk);
        req_call = 0; req_ret = 1;
        repeat (2) @(negedge clk);
        req_ret = 0;
        expect_eq("R8", "busy dropped", int'(busy), 0);
        expect_eq("R8", "sp after ignored ret", int'(sp_out), DEPTH - 2);
        fire(4'b0010, 0, 0, 0, cyc, dn);
        expect_eq("R8", "ip", int'(ip_out), 'h0C0C);

        // R5 mode sampled at acceptance
        cur_req = "R5";
        @(negedge clk);
        req_call = 1; ip_in = 16'h5151; seg_in = 8'h52;
        cfg_wr = 1; cfg_flat = 1; cfg_size = 0;
        @(negedge clk);
        req_call = 0; cfg_wr = 0;
        cyc = 0;
        while (busy) begin cyc++; @(negedge clk); end
        expect_eq("R5", "old mode used", cyc, 2);
        do_cfg(0, 0);
        fire(4'b0010, 0, 0, 0, cyc, dn);
        expect_eq("R5", "seg restored", int'(seg_out), 'h52);

        // R11 nested mixed events
        cur_req = "R11";
        fire(4'b0001, 'hA001, 'h01, 0, cyc, dn);
        fire(4'b0100, 'hA002, 'h02, 'hF002, cyc, dn);
        fire(4'b0001, 'hA003, 'h03, 0, cyc, dn);
        fire(4'b0010, 0, 0, 0, cyc, dn);
        expect_eq("R11", "inner ret ip", int'(ip_out), 'hA003);
        fire(4'b1000, 0, 0, 0, cyc, dn);
        expect_eq("R11", "iret psw", int'(psw_out), 'hF002);
        fire(4'b0010, 0, 0, 0, cyc, dn);
        expect_eq("R11", "outer ret ip", int'(ip_out), 'hA001);
        expect_eq("R11", "outer ret seg", int'(seg_out), 'h01);
        expect_eq("R11", "stack empty", int'(sp_out), 0);

        // R6 size codes and wrap-around
        cur_req = "R6";
        for (int code = 0; code < 8; code++) begin
            int s;
            s = size_of(code);
            do_reset();
            do_cfg(1, code);
            for (int i = 0; i < s + 3; i++) fire(4'b0001, i, 0, 0, cyc, dn);
            expect_eq("R6", $sformatf("sp code %0d", code), int'(sp_out), DEPTH - 3);
            if (code == 0) begin
                for (int i = 0; i < 32; i++) fire(4'b0010, 0, 0, 0, cyc, dn);
                expect_eq("R6", "oldest survivor", int'(ip_out), 3);
                expect_eq("R6", "sp back", int'(sp_out), DEPTH - 3);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule